// File: doc/BRIEF.md
# Repairable Speculative Return Stack

This block predicts return addresses for a speculative fetch front end. The caller pushes a return address when it predicts a call. It pops when it predicts a return and uses the popped value as the next fetch address. Each popped value comes with a checkpoint, which is the slot index and the value that slot held. A pop taken on a wrong path can therefore be repaired later with one restore. The restore writes the saved value back into the saved slot and moves the top pointer back to that slot. A separate undo-pop input cancels a push that the caller made on a wrong path. The caller should use undo-pop only when that call actually pushed.

Every hardware thread context has its own circular stack. The `tid_i` input selects the stack. The top pointer wraps modulo the depth. A push onto a full stack overwrites the oldest entry, and the block never stalls. The block takes one operation per cycle and always accepts it, so it has no ready signal and applies no back-pressure. The pop response is a valid-only stream that arrives one cycle after the pop. The consumer must take it in that cycle, because the response is not held.

Top module: `spec_ret_stack`

## Requirements
- R1: After reset, every thread's top index is 0, every slot holds 0, and `rsp_valid_o` is 0.
- R2: A push that takes effect advances the selected thread's top index by one, modulo DEPTH. It writes `push_addr_i` into the new top slot.
- R3: A pop that takes effect raises `rsp_valid_o` in the next cycle. In that cycle `rsp_target_o` carries the top slot's value and `rsp_idx_o` carries the top index, both as they were before the pop. The top index then decreases by one, modulo DEPTH.
- R4: A restore sets the selected thread's top index to `restore_idx_i` and writes `restore_tgt_i` into that slot, in one cycle. A following pop therefore returns exactly the checkpointed pair.
- R5: An undo-pop that takes effect decreases the top index by one. It produces no response, so `rsp_valid_o` stays 0 in the next cycle.
- R6: When several operations are requested in one cycle, only one takes effect. Priority order is restore, then push, then pop, then undo-pop. The requests that lose have no effect.
- R7: Operations change only the stack selected by `tid_i`. Every other thread's contents and top index are left unchanged.
- R8: A push onto a full stack never stalls. It overwrites the oldest entry, so after DEPTH+1 pushes the pops return only the last DEPTH addresses, newest first.
- R9: A pop on an empty stack still returns the value stored in the top slot and still moves the pointer. Right after reset this returns 0 with index 0, and then wraps to index DEPTH-1.
- R10: `rsp_valid_o` is 1 only in the cycle after a pop that took effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tid_i | input | TW = max(1, clog2(THREADS)) | Selects the thread's stack |
| push_i | input | 1 | Push request |
| push_addr_i | input | AW | Return address to push |
| pop_i | input | 1 | Pop request that produces a response |
| undo_i | input | 1 | Undo-pop request with no response, cancels a wrong-path push |
| restore_i | input | 1 | Restore request |
| restore_idx_i | input | IW = clog2(DEPTH) | Checkpointed slot index to restore |
| restore_tgt_i | input | AW | Checkpointed value to write into that slot |
| rsp_valid_o | output | 1 | Pop response valid, one cycle after the pop |
| rsp_target_o | output | AW | Popped return address (predicted fetch target) |
| rsp_idx_o | output | IW | Checkpoint index of the popped slot |

## Verification
The bench builds the block with DEPTH=4, THREADS=2 and AW=16. With a depth of four, a short run of pushes fills the stack and overwrites entries, and a few pops empty it and wrap the pointer below zero. This puts R8 and R9 within reach many times over in a few hundred random operations. Two threads are enough to show that operations on one stack leave the other untouched (R7). The narrow addresses keep the bench's model values easy to read when a check fails.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    LOP_IDLE    = 2'd0,
    LOP_PUSH    = 2'd1,
    LOP_DROP    = 2'd2,
    LOP_RESTORE = 2'd3
  } lane_op_e;
endpackage

// File: rtl/srs_arbiter.sv
module srs_arbiter
  import srs_pkg::*;
(
  input  logic     restore_req,
  input  logic     push_req,
  input  logic     pop_req,
  input  logic     undo_req,
  output lane_op_e op,
  output logic     rsp_req
);
  // single winner per cycle: restore > push > pop > undo
  always_comb begin
    op      = LOP_IDLE;
    rsp_req = 1'b0;
    if (restore_req)   op = LOP_RESTORE;
    else if (push_req) op = LOP_PUSH;
    else if (pop_req) begin
      op      = LOP_DROP;
      rsp_req = 1'b1;
    end
    else if (undo_req) op = LOP_DROP;
  end
endmodule

// File: rtl/srs_lane.sv
module srs_lane
  import srs_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  lane_op_e      op,
  input  logic [AW-1:0] push_addr,
  input  logic [IW-1:0] fix_idx,
  input  logic [AW-1:0] fix_val,
  output logic [IW-1:0] top_idx,
  output logic [AW-1:0] top_val
);
  logic [AW-1:0] slots [DEPTH];
  logic [IW-1:0] tos;
  logic [IW-1:0] tos_up;
  logic [IW-1:0] tos_dn;

  assign tos_up  = tos + IW'(1);
  assign tos_dn  = tos - IW'(1);
  assign top_idx = tos;
  assign top_val = slots[tos];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tos <= '0;
      for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
    end else if (en) begin
      unique case (op)
        LOP_PUSH: begin
          tos           <= tos_up;
          slots[tos_up] <= push_addr;
        end
        LOP_DROP: tos <= tos_dn;
        LOP_RESTORE: begin
          tos            <= fix_idx;
          slots[fix_idx] <= fix_val;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/srs_rsp.sv
module srs_rsp #(
  parameter int AW = 32,
  parameter int IW = 4
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [IW-1:0] idx_in,
  input  logic [AW-1:0] val_in,
  output logic          valid_o,
  output logic [AW-1:0] target_o,
  output logic [IW-1:0] idx_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o  <= 1'b0;
      target_o <= '0;
      idx_o    <= '0;
    end else begin
      valid_o <= req;
      if (req) begin
        target_o <= val_in;
        idx_o    <= idx_in;
      end
    end
  end
endmodule

// File: rtl/spec_ret_stack.sv
module spec_ret_stack
  import srs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int THREADS = 4,
  parameter int AW      = 32,
  localparam int IW     = $clog2(DEPTH),
  localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] tid_i,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  input  logic          undo_i,
  input  logic          restore_i,
  input  logic [IW-1:0] restore_idx_i,
  input  logic [AW-1:0] restore_tgt_i,
  output logic          rsp_valid_o,
  output logic [AW-1:0] rsp_target_o,
  output logic [IW-1:0] rsp_idx_o
);
  lane_op_e              op;
  logic                  rsp_req;
  logic [IW-1:0]         lane_idx [THREADS];
  logic [AW-1:0]         lane_val [THREADS];
  logic [THREADS*IW-1:0] tos_flat;
  logic [IW-1:0]         sel_idx;
  logic [AW-1:0]         sel_val;

  srs_arbiter u_arb (
    .restore_req (restore_i),
    .push_req    (push_i),
    .pop_req     (pop_i),
    .undo_req    (undo_i),
    .op          (op),
    .rsp_req     (rsp_req)
  );

  for (genvar t = 0; t < THREADS; t++) begin : g_lane
    srs_lane #(.DEPTH(DEPTH), .AW(AW)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (int'(tid_i) == t),
      .op        (op),
      .push_addr (push_addr_i),
      .fix_idx   (restore_idx_i),
      .fix_val   (restore_tgt_i),
      .top_idx   (lane_idx[t]),
      .top_val   (lane_val[t])
    );
    assign tos_flat[t*IW +: IW] = lane_idx[t];
  end

  always_comb begin
    sel_idx = '0;
    sel_val = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (int'(tid_i) == t) begin
        sel_idx = lane_idx[t];
        sel_val = lane_val[t];
      end
    end
  end

  srs_rsp #(.AW(AW), .IW(IW)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (rsp_req),
    .idx_in   (sel_idx),
    .val_in   (sel_val),
    .valid_o  (rsp_valid_o),
    .target_o (rsp_target_o),
    .idx_o    (rsp_idx_o)
  );
endmodule

// File: rtl/spec_ret_stack_chk.sv
module spec_ret_stack_chk #(
  parameter int DEPTH   = 16,
  parameter int THREADS = 4,
  localparam int IW     = $clog2(DEPTH),
  localparam int TW     = (THREADS > 1) ? $clog2(THREADS) : 1
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic [TW-1:0]         tid_i,
  input logic                  push_i,
  input logic                  pop_i,
  input logic                  undo_i,
  input logic                  restore_i,
  input logic [IW-1:0]         restore_idx_i,
  input logic                  rsp_valid_o,
  input logic [IW-1:0]         rsp_idx_o,
  input logic [THREADS*IW-1:0] tos_flat
);
  function automatic logic [IW-1:0] top_of(input logic [TW-1:0] t);
    return tos_flat[int'(t)*IW +: IW];
  endfunction

  logic pop_wins, undo_wins;
  assign pop_wins  = pop_i && !push_i && !restore_i;
  assign undo_wins = undo_i && !pop_i && !push_i && !restore_i;

  assert_restore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> top_of($past(tid_i)) == $past(restore_idx_i));

  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !restore_i) |=> top_of($past(tid_i)) == IW'($past(top_of(tid_i)) + IW'(1)));

  assert_pop_ckpt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop_wins |=> rsp_valid_o && rsp_idx_o == $past(top_of(tid_i)));

  assert_quiet_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_wins |=> !rsp_valid_o);

  assert_undo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    undo_wins |=> top_of($past(tid_i)) == IW'($past(top_of(tid_i)) - IW'(1)));

  for (genvar t = 0; t < THREADS; t++) begin : g_iso
    assert_isolation_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(tid_i) != t) |=> $stable(tos_flat[t*IW +: IW]));
  end
endmodule

bind spec_ret_stack spec_ret_stack_chk #(.DEPTH(DEPTH), .THREADS(THREADS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tid_i         (tid_i),
  .push_i        (push_i),
  .pop_i         (pop_i),
  .undo_i        (undo_i),
  .restore_i     (restore_i),
  .restore_idx_i (restore_idx_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_idx_o     (rsp_idx_o),
  .tos_flat      (tos_flat)
);

// File: tb/spec_ret_stack_tb.sv
`timescale 1ns/1ps
module spec_ret_stack_tb;
  localparam int TD = 4;
  localparam int TT = 2;
  localparam int TA = 16;
  localparam int IW = $clog2(TD);
  localparam int TW = (TT > 1) ? $clog2(TT) : 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] tid_i = '0;
  logic          push_i = 1'b0, pop_i = 1'b0, undo_i = 1'b0, restore_i = 1'b0;
  logic [TA-1:0] push_addr_i = '0, restore_tgt_i = '0;
  logic [IW-1:0] restore_idx_i = '0;
  logic          rsp_valid_o;
  logic [TA-1:0] rsp_target_o;
  logic [IW-1:0] rsp_idx_o;

  int n_tests = 0, n_fail = 0;
  int ref_tos [TT];
  logic [TA-1:0] ref_mem [TT][TD];
  logic [TA-1:0] ck_val;
  int ck_idx;

  always #2 clk = ~clk;

  spec_ret_stack #(.DEPTH(TD), .THREADS(TT), .AW(TA)) u_dut (.*);

  function automatic int wrap(input int v);
    return ((v % TD) + TD) % TD;
  endfunction

  task automatic check(input string tag, input bit ev, input logic [TA-1:0] et, input int ei);
    n_tests++;
    if (rsp_valid_o !== ev || (ev && (rsp_target_o !== et || int'(rsp_idx_o) != ei))) begin
      n_fail++;
      $display("FAIL %s: valid=%0b tgt=%h idx=%0d expected valid=%0b tgt=%h idx=%0d",
               tag, rsp_valid_o, rsp_target_o, rsp_idx_o, ev, et, ei);
    end
  endtask

  // called at a negedge: drive, model, wait one cycle, check at next negedge
  task automatic step(input bit rs, input bit ps, input bit pp, input bit ud, input int t,
                      input logic [TA-1:0] a, input int ri, input logic [TA-1:0] rt,
                      input string tag);
    bit ev = 0;
    logic [TA-1:0] et = '0;
    int ei = 0;
    tid_i = TW'(t); restore_i = rs; push_i = ps; pop_i = pp; undo_i = ud;
    push_addr_i = a; restore_idx_i = IW'(ri); restore_tgt_i = rt;
    if (rs) begin
      ref_tos[t] = ri; ref_mem[t][ri] = rt;
    end else if (ps) begin
      ref_tos[t] = wrap(ref_tos[t] + 1); ref_mem[t][ref_tos[t]] = a;
    end else if (pp) begin
      ev = 1; et = ref_mem[t][ref_tos[t]]; ei = ref_tos[t];
      ref_tos[t] = wrap(ref_tos[t] - 1);
    end else if (ud) begin
      ref_tos[t] = wrap(ref_tos[t] - 1);
    end
    @(negedge clk);
    restore_i = 0; push_i = 0; pop_i = 0; undo_i = 0;
    check(tag, ev, et, ei);
    if (ev) begin ck_val = et; ck_idx = ei; end
  endtask

  initial begin
    #800000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int t = 0; t < TT; t++) begin
      ref_tos[t] = 0;
      for (int i = 0; i < TD; i++) ref_mem[t][i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset valid low", 0, '0, 0);
    // R1/R9: pop on fresh stack gives 0 at index 0, then wraps to DEPTH-1
    step(0,0,1,0, 0, '0, 0, '0, "R1 R9 empty pop");
    step(0,0,1,0, 0, '0, 0, '0, "R9 wrap pop");
    // R2/R3
    step(0,1,0,0, 0, 16'hA001, 0, '0, "R2 push");
    step(0,1,0,0, 0, 16'hA002, 0, '0, "R2 push");
    step(0,0,1,0, 0, '0, 0, '0, "R3 pop newest");
    step(0,0,1,0, 0, '0, 0, '0, "R3 pop older");
    // R8: overfill thread 1
    for (int k = 0; k < TD + 1; k++) step(0,1,0,0, 1, TA'(16'hB000 + k), 0, '0, "R8 fill");
    for (int k = 0; k < TD; k++) step(0,0,1,0, 1, '0, 0, '0, "R8 pop after overwrite");
    // R4: wrong-path pop then push clobbers slot, restore repairs
    step(0,1,0,0, 0, 16'hC0DE, 0, '0, "R2 push");
    step(0,0,1,0, 0, '0, 0, '0, "R3 pop checkpoint");
    step(0,1,0,0, 0, 16'hDEAD, 0, '0, "R2 clobber");
    step(1,0,0,0, 0, '0, ck_idx, ck_val, "R4 restore");
    step(0,0,1,0, 0, '0, 0, '0, "R4 pop after restore");
    // R6: restore beats push and pop
    step(1,1,1,0, 0, 16'h1111, 2, 16'h7777, "R6 restore wins");
    step(0,0,1,0, 0, '0, 0, '0, "R6 pop shows restore only");
    step(0,1,1,1, 0, 16'h2222, 0, '0, "R6 push beats pop");
    step(0,0,1,0, 0, '0, 0, '0, "R6 pop after push");
    // R5: undo cancels wrong-path push
    step(0,1,0,0, 0, 16'h3333, 0, '0, "R2 push");
    step(0,1,0,0, 0, 16'h4444, 0, '0, "R2 push");
    step(0,0,0,1, 0, '0, 0, '0, "R5 undo no rsp");
    step(0,0,1,0, 0, '0, 0, '0, "R5 pop after undo");
    // R7: thread 1 untouched by thread 0 traffic
    step(0,1,0,0, 1, 16'h5555, 0, '0, "R7 push t1");
    step(0,1,0,0, 0, 16'h6666, 0, '0, "R7 push t0");
    step(1,0,0,0, 0, '0, 1, 16'h0F0F, "R7 restore t0");
    step(0,0,1,0, 1, '0, 0, '0, "R7 pop t1 own value");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r = $urandom_range(0, 99);
      int t = $urandom_range(0, TT - 1);
      bit rs = (r < 10), ps = ($urandom_range(0, 2) == 0), pp = ($urandom_range(0, 2) == 0);
      bit ud = ($urandom_range(0, 5) == 0);
      step(rs, ps, pp, ud, t, TA'($urandom), $urandom_range(0, TD - 1), TA'($urandom),
           pp ? "R3 R6 random" : "R10 random");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule